// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block makes the keep-or-discard decision for each received Ethernet frame. A front end that has already parsed the frame and checked its CRC presents a per-frame summary: the 48-bit destination address, the EtherType, the frame length in bytes and a CRC-good flag. It marks the frame as complete with a one-cycle end-of-frame strobe. The filter weighs this summary against a 16-bit control word, a 48-bit station address and a maximum frame length. One cycle later it reports accept or drop with a valid strobe and a reason code that says which rule decided.

The rules run in a fixed order. The receive enable comes first, then the pass-all promiscuous setting. The error conditions follow: CRC error, runt, oversize and MAC control frame. The address class comes last: broadcast, multicast or unicast, with optional station-address matching for unicast. Each error condition has its own bit that accepts it instead of dropping it.

The station address is held in three 16-bit words (high, mid and low). Inside each word the first wire byte sits in the low half. Configuration inputs are sampled on the end-of-frame cycle only.

Top module: `rx_frame_filter`

## Requirements
- R1: The verdict (`dec_valid_o` high, with `accept_o` and `reason_o`) appears in the cycle after `eof_i` is sampled high. `dec_valid_o` is high only then. Between verdicts, `accept_o` and `reason_o` hold their last values.
- R2: After synchronous reset, `dec_valid_o` and `accept_o` are 0 and `reason_o` is 0.
- R3: When control bit 12 (receive enable) is 0, every frame is dropped with reason 1, whatever the other bits are.
- R4: When the receive enable is set and control bits 1:0 equal 1, every frame is accepted with reason 2. The values 0, 2 and 3 select normal filtering.
- R5: A frame with `crc_ok_i` low is dropped with reason 3 unless control bit 4 is set.
- R6: A frame with length below 64 is a runt. It is dropped with reason 4 unless control bit 5 is set.
- R7: A frame with length strictly greater than `max_len_i` is oversize. It is dropped with reason 5 unless control bit 7 is set. A length equal to `max_len_i` is not oversize.
- R8: A frame with EtherType 0x8808 is a control frame. It is dropped with reason 6 unless control bit 6 is set.
- R9: The error conditions are checked in the order CRC, runt, oversize, control. All of them are checked before the address class. The first unaccepted error sets the reason.
- R10: An all-ones destination is broadcast. It is accepted with reason 7 if control bit 2 is set, and otherwise dropped with reason 8.
- R11: A destination whose first wire byte (`dst_i[47:40]`) has bit 0 set, and which is not broadcast, is multicast. It is accepted with reason 9 if control bit 3 is set, and otherwise dropped with reason 10.
- R12: Any other destination is unicast. With control bit 8 clear it is accepted with reason 11. With bit 8 set it is accepted with reason 12 if it equals the station address, and otherwise dropped with reason 13. The station address is formed as {hi[7:0], hi[15:8], mid[7:0], mid[15:8], lo[7:0], lo[15:8]}, compared against `dst_i` with its first wire byte in bits 47:40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 16 | Filter control word |
| sta_hi_i | input | 16 | Station address high word (wire bytes 0,1, byte 0 in low half) |
| sta_mid_i | input | 16 | Station address mid word (wire bytes 2,3) |
| sta_lo_i | input | 16 | Station address low word (wire bytes 4,5) |
| max_len_i | input | 16 | Largest frame length that is not oversize |
| eof_i | input | 1 | End-of-frame strobe; the frame summary is valid with it |
| dst_i | input | 48 | Destination address, first wire byte in bits 47:40 |
| etype_i | input | 16 | EtherType / length field |
| len_i | input | 16 | Frame length in bytes |
| crc_ok_i | input | 1 | CRC check passed |
| dec_valid_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | 1 = accept, 0 = drop |
| reason_o | output | 4 | Code of the rule that decided |

## Verification
Every result of this block arrives exactly one clock after the end-of-frame strobe, through a single output register. The bench drives the frame summary on a falling edge with the strobe high. It reads the verdict, accept bit and reason code on the next falling edge, half a cycle after the registering edge. On the falling edge after that, it confirms that the strobe has dropped and that the accept bit and reason code are unchanged. Expected values come from a bench function that applies the rule order, seeded random frames are mixed with directed frames at the length limits and address classes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W  = 48;
    localparam int WORD_W  = 16;
    localparam int N_WORDS = ADDR_W / WORD_W;

    // control word bit positions
    localparam int CB_PRM_LO = 0;
    localparam int CB_PRM_HI = 1;
    localparam int CB_BCAST  = 2;
    localparam int CB_MCAST  = 3;
    localparam int CB_CRC    = 4;
    localparam int CB_RUNT   = 5;
    localparam int CB_CTRL   = 6;
    localparam int CB_OVER   = 7;
    localparam int CB_DAF    = 8;
    localparam int CB_RXEN   = 12;

    localparam logic [1:0] PRM_PASS_ALL = 2'd1;

    typedef enum logic [3:0] {
        RS_NONE      = 4'd0,
        RS_DISABLED  = 4'd1,
        RS_PROMISC   = 4'd2,
        RS_CRC       = 4'd3,
        RS_RUNT      = 4'd4,
        RS_OVERSIZE  = 4'd5,
        RS_CONTROL   = 4'd6,
        RS_BCAST_OK  = 4'd7,
        RS_BCAST_REJ = 4'd8,
        RS_MCAST_OK  = 4'd9,
        RS_MCAST_REJ = 4'd10,
        RS_UCAST_ANY = 4'd11,
        RS_UCAST_HIT = 4'd12,
        RS_UCAST_MISS= 4'd13
    } rxf_reason_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [15:0]       etype;
        logic [15:0]       len;
        logic              crc_ok;
    } rxf_frame_t;

    typedef struct packed {
        logic crc_bad;
        logic runt;
        logic oversize;
        logic control;
        logic bcast;
        logic mcast;
        logic ucast_hit;
    } rxf_flags_t;

    typedef struct packed {
        logic        accept;
        rxf_reason_e reason;
    } rxf_verdict_t;

    // register word -> wire order (first wire byte sits in the low half)
    function automatic logic [WORD_W-1:0] wire_order(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/rxf_station.sv
module rxf_station
    import rxf_pkg::*;
(
    input  logic [WORD_W-1:0] sta_hi_i,
    input  logic [WORD_W-1:0] sta_mid_i,
    input  logic [WORD_W-1:0] sta_lo_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic              hit_o
);
    logic [WORD_W-1:0] words [N_WORDS];
    logic [ADDR_W-1:0] station;
    logic [N_WORDS-1:0] word_eq;

    assign words[0] = sta_hi_i;
    assign words[1] = sta_mid_i;
    assign words[2] = sta_lo_i;

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        localparam int TOP = ADDR_W - 1 - i * WORD_W;
        assign station[TOP -: WORD_W] = wire_order(words[i]);
        assign word_eq[i] = (station[TOP -: WORD_W] == dst_i[TOP -: WORD_W]);
    end

    assign hit_o = &word_eq;
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int          MIN_LEN    = 64,
    parameter logic [15:0] CTRL_ETYPE = 16'h8808
)(
    input  rxf_frame_t  frame_i,
    input  logic [15:0] max_len_i,
    input  logic        hit_i,
    output rxf_flags_t  flags_o
);
    localparam logic [15:0] MIN_LEN_V = 16'(MIN_LEN);
    localparam int          FIRST_LSB = ADDR_W - 8;

    logic all_ones;

    always_comb begin
        all_ones          = &frame_i.dst;
        flags_o.crc_bad   = !frame_i.crc_ok;
        flags_o.runt      = frame_i.len < MIN_LEN_V;
        flags_o.oversize  = frame_i.len > max_len_i;
        flags_o.control   = frame_i.etype == CTRL_ETYPE;
        flags_o.bcast     = all_ones;
        flags_o.mcast     = frame_i.dst[FIRST_LSB] && !all_ones;
        flags_o.ucast_hit = hit_i;
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic [15:0]  ctrl_i,
    input  rxf_flags_t   flags_i,
    output rxf_verdict_t verdict_o
);
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl_i[15:13], ctrl_i[11:9]};

    always_comb begin
        verdict_o.accept = 1'b0;
        verdict_o.reason = RS_NONE;
        if (!ctrl_i[CB_RXEN]) begin
            verdict_o.reason = RS_DISABLED;
        end else if (ctrl_i[CB_PRM_HI:CB_PRM_LO] == PRM_PASS_ALL) begin
            verdict_o.accept = 1'b1;
            verdict_o.reason = RS_PROMISC;
        end else if (flags_i.crc_bad && !ctrl_i[CB_CRC]) begin
            verdict_o.reason = RS_CRC;
        end else if (flags_i.runt && !ctrl_i[CB_RUNT]) begin
            verdict_o.reason = RS_RUNT;
        end else if (flags_i.oversize && !ctrl_i[CB_OVER]) begin
            verdict_o.reason = RS_OVERSIZE;
        end else if (flags_i.control && !ctrl_i[CB_CTRL]) begin
            verdict_o.reason = RS_CONTROL;
        end else if (flags_i.bcast) begin
            verdict_o.accept = ctrl_i[CB_BCAST];
            verdict_o.reason = ctrl_i[CB_BCAST] ? RS_BCAST_OK : RS_BCAST_REJ;
        end else if (flags_i.mcast) begin
            verdict_o.accept = ctrl_i[CB_MCAST];
            verdict_o.reason = ctrl_i[CB_MCAST] ? RS_MCAST_OK : RS_MCAST_REJ;
        end else if (!ctrl_i[CB_DAF]) begin
            verdict_o.accept = 1'b1;
            verdict_o.reason = RS_UCAST_ANY;
        end else begin
            verdict_o.accept = flags_i.ucast_hit;
            verdict_o.reason = flags_i.ucast_hit ? RS_UCAST_HIT : RS_UCAST_MISS;
        end
    end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int          MIN_LEN    = 64,
    parameter logic [15:0] CTRL_ETYPE = 16'h8808
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ctrl_i,
    input  logic [15:0] sta_hi_i,
    input  logic [15:0] sta_mid_i,
    input  logic [15:0] sta_lo_i,
    input  logic [15:0] max_len_i,
    input  logic        eof_i,
    input  logic [47:0] dst_i,
    input  logic [15:0] etype_i,
    input  logic [15:0] len_i,
    input  logic        crc_ok_i,
    output logic        dec_valid_o,
    output logic        accept_o,
    output logic [3:0]  reason_o
);
    rxf_frame_t   frame;
    rxf_flags_t   flags;
    rxf_verdict_t verdict;
    rxf_verdict_t verdict_q;
    logic         hit;

    assign frame.dst    = dst_i;
    assign frame.etype  = etype_i;
    assign frame.len    = len_i;
    assign frame.crc_ok = crc_ok_i;

    rxf_station u_station (
        .sta_hi_i  (sta_hi_i),
        .sta_mid_i (sta_mid_i),
        .sta_lo_i  (sta_lo_i),
        .dst_i     (dst_i),
        .hit_o     (hit)
    );

    rxf_classify #(
        .MIN_LEN    (MIN_LEN),
        .CTRL_ETYPE (CTRL_ETYPE)
    ) u_classify (
        .frame_i   (frame),
        .max_len_i (max_len_i),
        .hit_i     (hit),
        .flags_o   (flags)
    );

    rxf_decide u_decide (
        .ctrl_i    (ctrl_i),
        .flags_i   (flags),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid_o <= 1'b0;
            verdict_q   <= '{accept: 1'b0, reason: RS_NONE};
        end else begin
            dec_valid_o <= eof_i;
            if (eof_i) begin
                verdict_q <= verdict;
            end
        end
    end

    assign accept_o = verdict_q.accept;
    assign reason_o = verdict_q.reason;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ctrl_i,
    input logic        eof_i,
    input logic        crc_ok_i,
    input logic        dec_valid_o,
    input logic        accept_o,
    input logic [3:0]  reason_o
);
    assert_valid_after_eof_R1: assert property (@(posedge clk) disable iff (rst)
        eof_i |=> dec_valid_o);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !eof_i |=> !dec_valid_o);

    assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_o |-> ($stable(accept_o) && $stable(reason_o)));

    assert_disabled_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (eof_i && !ctrl_i[12]) |=> (!accept_o && reason_o == 4'd1));

    assert_pass_all_R4: assert property (@(posedge clk) disable iff (rst)
        (eof_i && ctrl_i[12] && ctrl_i[1:0] == 2'd1) |=> accept_o);

    assert_crc_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (eof_i && ctrl_i[12] && ctrl_i[1:0] != 2'd1 && !crc_ok_i && !ctrl_i[4])
        |=> (!accept_o && reason_o == 4'd3));
endmodule

bind rx_frame_filter rxf_checker u_rxf_checker (
    .clk         (clk),
    .rst         (rst),
    .ctrl_i      (ctrl_i),
    .eof_i       (eof_i),
    .crc_ok_i    (crc_ok_i),
    .dec_valid_o (dec_valid_o),
    .accept_o    (accept_o),
    .reason_o    (reason_o)
);

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_i = '0;
    logic [15:0] sta_hi_i, sta_mid_i, sta_lo_i;
    logic [15:0] max_len_i;
    logic        eof_i = 1'b0;
    logic [47:0] dst_i = '0;
    logic [15:0] etype_i = '0;
    logic [15:0] len_i = '0;
    logic        crc_ok_i = 1'b1;
    logic        dec_valid_o, accept_o;
    logic [3:0]  reason_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam logic [15:0] MAXL    = 16'd1518;

    always #4 clk = ~clk;

    rx_frame_filter u_dut (
        .clk(clk), .rst(rst), .ctrl_i(ctrl_i),
        .sta_hi_i(sta_hi_i), .sta_mid_i(sta_mid_i), .sta_lo_i(sta_lo_i),
        .max_len_i(max_len_i), .eof_i(eof_i), .dst_i(dst_i),
        .etype_i(etype_i), .len_i(len_i), .crc_ok_i(crc_ok_i),
        .dec_valid_o(dec_valid_o), .accept_o(accept_o), .reason_o(reason_o)
    );

    // Reference model: returns {accept, reason}
    function automatic logic [4:0] expect_v(input logic [15:0] c, input logic [47:0] d,
                                            input logic [15:0] et, input logic [15:0] ln,
                                            input logic crc);
        logic bc, mc;
        bc = (d == 48'hFFFF_FFFF_FFFF);
        mc = d[40] && !bc;
        if (!c[12])                     return {1'b0, 4'd1};
        if (c[1:0] == 2'd1)             return {1'b1, 4'd2};
        if (!crc && !c[4])              return {1'b0, 4'd3};
        if (ln < 16'd64 && !c[5])       return {1'b0, 4'd4};
        if (ln > MAXL && !c[7])         return {1'b0, 4'd5};
        if (et == 16'h8808 && !c[6])    return {1'b0, 4'd6};
        if (bc)                         return c[2] ? {1'b1, 4'd7} : {1'b0, 4'd8};
        if (mc)                         return c[3] ? {1'b1, 4'd9} : {1'b0, 4'd10};
        if (!c[8])                      return {1'b1, 4'd11};
        if (d == STATION)               return {1'b1, 4'd12};
        return {1'b0, 4'd13};
    endfunction

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7, 4'd8: return "R10";
            4'd9, 4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic frame(input string req, input logic [15:0] c, input logic [47:0] d,
                         input logic [15:0] et, input logic [15:0] ln, input logic crc);
        logic [4:0] e;
        string tag;
        e = expect_v(c, d, et, ln, crc);
        tag = (req == "") ? tag_of(e[3:0]) : req;
        @(negedge clk);
        ctrl_i = c; dst_i = d; etype_i = et; len_i = ln; crc_ok_i = crc; eof_i = 1'b1;
        @(negedge clk);
        eof_i = 1'b0;
        ctrl_i = ~c; dst_i = ~d; crc_ok_i = ~crc;  // disturb; must not matter without eof
        check("R1 valid", {7'd0, dec_valid_o}, 8'd1);
        check(tag, {3'd0, accept_o, reason_o}, {3'd0, e});
        @(negedge clk);
        check("R1 hold", {2'd0, dec_valid_o, accept_o, reason_o}, {2'd0, 1'b0, e});
    endtask

    initial begin
        sta_hi_i  = {STATION[39:32], STATION[47:40]};
        sta_mid_i = {STATION[23:16], STATION[31:24]};
        sta_lo_i  = {STATION[7:0],   STATION[15:8]};
        max_len_i = MAXL;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] base;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        base = 16'h1000;  // enable only, normal mode
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2", {5'd0, dec_valid_o, accept_o, 1'b0}, 8'd0);
        check("R2", {4'd0, reason_o}, 8'd0);
        rst = 1'b0;

        // R3 enable clear beats pass-all and accept bits
        frame("R3", 16'h0FFD, STATION, 16'h0800, 16'd100, 1'b1);
        // R4 pass-all even with errors; value 3 is normal
        frame("R4", base | 16'h0001, 48'h0, 16'h8808, 16'd10, 1'b0);
        frame("R4", base | 16'h0003, 48'h001122334455, 16'h0800, 16'd100, 1'b0);
        // R5 crc
        frame("R5", base, STATION, 16'h0800, 16'd100, 1'b0);
        frame("R5", base | 16'h0010, 48'h0A0000000001, 16'h0800, 16'd100, 1'b0);
        // R6 runt boundary
        frame("R6", base, STATION, 16'h0800, 16'd63, 1'b1);
        frame("R6", base, STATION, 16'h0800, 16'd64, 1'b1);
        frame("R6", base | 16'h0020, STATION, 16'h0800, 16'd63, 1'b1);
        // R7 oversize boundary
        frame("R7", base, STATION, 16'h0800, MAXL, 1'b1);
        frame("R7", base, STATION, 16'h0800, MAXL + 16'd1, 1'b1);
        frame("R7", base | 16'h0080, STATION, 16'h0800, MAXL + 16'd1, 1'b1);
        // R8 control
        frame("R8", base | 16'h0004, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'd64, 1'b1);
        frame("R8", base | 16'h0044, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'd64, 1'b1);
        // R9 priority: crc over runt, runt over control, oversize over control
        frame("R9", base, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'd20, 1'b0);
        frame("R9", base | 16'h0010, STATION, 16'h8808, 16'd20, 1'b0);
        frame("R9", base | 16'h0030, STATION, 16'h8808, 16'd2000, 1'b0);
        // R10 broadcast
        frame("R10", base, 48'hFFFF_FFFF_FFFF, 16'h0800, 16'd64, 1'b1);
        frame("R10", base | 16'h0004, 48'hFFFF_FFFF_FFFF, 16'h0800, 16'd64, 1'b1);
        // R11 multicast
        frame("R11", base | 16'h0004, 48'h01005E000001, 16'h0800, 16'd64, 1'b1);
        frame("R11", base | 16'h0008, 48'h01005E000001, 16'h0800, 16'd64, 1'b1);
        // R12 unicast
        frame("R12", base, 48'h001122334455, 16'h0800, 16'd64, 1'b1);
        frame("R12", base | 16'h0100, STATION, 16'h0800, 16'd64, 1'b1);
        frame("R12", base | 16'h0100, STATION ^ 48'h1, 16'h0800, 16'd64, 1'b1);
        frame("R12", base | 16'h0100, STATION ^ 48'h0000_0100_0000, 16'h0800, 16'd64, 1'b1);

        // seeded random frames
        for (int i = 0; i < 300; i++) begin
            logic [15:0] c, ln, et;
            logic [47:0] d;
            logic crc;
            c = 16'($urandom);
            if ($urandom_range(0, 7) != 0) c[12] = 1'b1;
            case ($urandom_range(0, 3))
                0: d = 48'hFFFF_FFFF_FFFF;
                1: d = {8'h01 | 8'($urandom), 40'($urandom)};
                2: d = STATION;
                default: d = {8'($urandom) & 8'hFE, 40'($urandom)};
            endcase
            case ($urandom_range(0, 4))
                0: ln = 16'd63;
                1: ln = 16'd64;
                2: ln = MAXL;
                3: ln = MAXL + 16'd1;
                default: ln = 16'($urandom_range(0, 3000));
            endcase
            et  = ($urandom_range(0, 3) == 0) ? 16'h8808 : 16'h0800;
            crc = ($urandom_range(0, 3) != 0);
            frame("", c, d, et, ln, crc);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule